// File: doc/BRIEF.md
# Handshaked Parallel Sample Output Port

This block hands complex baseband samples from a receiver's processing channels to an external processor over a 16-bit parallel bus. Six internal sample streams are offered to it. A source selector admits one of them into a small sample buffer. Each buffered complex sample leaves the block as two bus words: the in-phase word first, then the quadrature word. Both words carry the 2-bit number of the processing channel that produced the sample, and a phase flag tells the processor which half of the pair is on the bus.

The transfer uses a request/acknowledge handshake that is timed by a port clock. The block raises request and updates the word when the port clock rises. It samples acknowledge when the port clock falls. As clock master, the block makes the port clock itself by dividing the core clock, and the divisor is selectable. As clock slave, the port clock arrives from outside and is resynchronised into the core clock domain. When the buffer is full, any further incoming sample is discarded and a sticky overflow flag is raised.

Top module: `par_sample_port`

## Requirements
- R1: While reset is active, and just after it, port_req, port_iq, port_data, port_chan, pclk_out and ovf_flag are all 0.
- R2: Setting src_sel to a value s from 0 to 5 admits only samples of source s, which are those with src_valid[s]=1, I from src_i[16s+15:16s], Q from src_q[16s+15:16s] and channel from src_chan[2s+1:2s]. Samples from every other source are ignored. Values 6 and 7 admit nothing, and port_req stays 0.
- R3: Every admitted sample produces exactly two words. The first has port_iq=1 and port_data=I. The second has port_iq=0 and port_data=Q. Both words carry the sample's channel number on port_chan.
- R4: A word counts as transferred only when port_req is 1 and port_ack is 1 at a falling edge of the port clock. Otherwise the word stays on the bus unchanged.
- R5: port_req, port_data, port_chan and port_iq change only at a rising edge of the port clock.
- R6: port_req stays 1 while words remain to be sent. It falls only at the first rising port-clock edge after the Q word of the last buffered sample has been transferred.
- R7: In master mode (clk_master=1), pclk_out is the port clock. With clk_div = d, its period is 2^(d+1) core cycles, and it rises and falls at core clock edges.
- R8: In slave mode (clk_master=0), pclk_in is the port clock and pclk_out is held at 0. pclk_in passes through a two-stage synchroniser, so the block acts on each of its edges at the third core edge after the edge appears.
- R9: The buffer holds 4 samples in addition to the sample currently being sent. A sample that arrives while the buffer is full is discarded and sets ovf_flag. ovf_flag then stays at 1 until reset.
- R10: Samples leave the block in the order they were admitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 3 | Source selector (0 to 5, other values select none) |
| src_valid | input | 6 | Per-source sample strobe |
| src_i | input | 96 | In-phase values, 16 bits per source |
| src_q | input | 96 | Quadrature values, 16 bits per source |
| src_chan | input | 12 | Channel numbers, 2 bits per source |
| clk_master | input | 1 | 1: generate port clock, 0: use pclk_in |
| clk_div | input | 2 | Master divisor exponent d |
| pclk_in | input | 1 | Port clock in slave mode |
| pclk_out | output | 1 | Generated port clock in master mode |
| port_req | output | 1 | Word-available request |
| port_ack | input | 1 | Processor acknowledge |
| port_data | output | 16 | Output word |
| port_chan | output | 2 | Channel number of the word on the bus |
| port_iq | output | 1 | 1 for an I word, 0 for a Q word |
| ovf_flag | output | 1 | Sticky buffer overflow |

## Verification
A new sample reaches the buffer one core cycle after its strobe and appears on the bus at the next rising edge of the port clock. A word is transferred at a falling edge of the port clock, and the next word follows at the rising edge after that. In slave mode both actions happen three core edges after the pclk_in edge that causes them. The bench samples every port at the falling edge of the core clock. It detects port-clock edges at the port, either on pclk_out or on the pclk_in it drives itself, and it decides each transfer from the request and acknowledge values seen just before the falling port-clock edge. In slave mode it changes acknowledge only at rising edges of pclk_in and keeps each half period at six core cycles, so the three-cycle synchroniser delay ends while the bus is still stable. The overflow flag is checked three core cycles after the last strobe.

// File: rtl/par_sample_pkg.sv
package par_sample_pkg;

    localparam int SMP_W = 16;
    localparam int CH_W  = 2;

    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic [SMP_W-1:0] i;
        logic [SMP_W-1:0] q;
    } sample_t;

endpackage

// File: rtl/psp_clkgen.sv
module psp_clkgen #(
    parameter int DIVW = 2,
    parameter int SYNC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            master,
    input  logic [DIVW-1:0] div_exp,
    input  logic            pclk_in,
    output logic            pclk_out,
    output logic            rise_ev,
    output logic            fall_ev
);
    localparam int CNTW = (1 << DIVW) - 1;

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic            pclk;
        logic [SYNC-1:0] sync;
        logic            prev;
    } st_t;

    st_t st_q, st_d;
    logic [CNTW-1:0] lim;
    logic            wrap;
    logic            ext_lvl;

    always_comb begin
        lim     = CNTW'((32'd1 << div_exp) - 32'd1);
        wrap    = (st_q.cnt >= lim);
        ext_lvl = st_q.sync[SYNC-1];
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC-2:0], pclk_in};
        st_d.prev = ext_lvl;
        if (master) begin
            if (wrap) begin
                st_d.cnt  = '0;
                st_d.pclk = ~st_q.pclk;
            end else begin
                st_d.cnt = st_q.cnt + CNTW'(1);
            end
        end else begin
            st_d.cnt  = '0;
            st_d.pclk = 1'b0;
        end
        rise_ev  = master ? (wrap && !st_q.pclk) : (ext_lvl && !st_q.prev);
        fall_ev  = master ? (wrap && st_q.pclk)  : (!ext_lvl && st_q.prev);
        pclk_out = st_q.pclk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/psp_srcmux.sv
module psp_srcmux
    import par_sample_pkg::*;
#(
    parameter int NSRC = 6,
    parameter int SELW = 3
) (
    input  logic [SELW-1:0]       sel,
    input  logic [NSRC-1:0]       valid,
    input  logic [NSRC*SMP_W-1:0] i_bus,
    input  logic [NSRC*SMP_W-1:0] q_bus,
    input  logic [NSRC*CH_W-1:0]  ch_bus,
    output logic                  out_valid,
    output sample_t               out_smp
);
    sample_t cand [NSRC];

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign cand[s].chan = ch_bus[s*CH_W +: CH_W];
        assign cand[s].i    = i_bus[s*SMP_W +: SMP_W];
        assign cand[s].q    = q_bus[s*SMP_W +: SMP_W];
    end

    always_comb begin
        out_valid = 1'b0;
        out_smp   = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (sel == SELW'(s)) begin
                out_valid = valid[s];
                out_smp   = cand[s];
            end
        end
    end

endmodule

// File: rtl/psp_fifo.sv
module psp_fifo
    import par_sample_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_en,
    input  sample_t wr_data,
    input  logic    rd_en,
    output sample_t rd_data,
    output logic    empty,
    output logic    ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
        logic          ovf;
    } st_t;

    st_t     st_q, st_d;
    sample_t mem [DEPTH];
    logic    full, do_wr, do_rd;

    always_comb begin
        full  = (st_q.cnt == (AW+1)'(DEPTH));
        empty = (st_q.cnt == '0);
        do_wr = wr_en && !full;
        do_rd = rd_en && !empty;
        st_d  = st_q;
        if (do_wr) st_d.wp = (st_q.wp == AW'(DEPTH-1)) ? '0 : st_q.wp + AW'(1);
        if (do_rd) st_d.rp = (st_q.rp == AW'(DEPTH-1)) ? '0 : st_q.rp + AW'(1);
        st_d.cnt = st_q.cnt + (AW+1)'(do_wr) - (AW+1)'(do_rd);
        if (wr_en && full) st_d.ovf = 1'b1;
        rd_data = mem[st_q.rp];
        ovf     = st_q.ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[st_q.wp] <= wr_data;
    end

endmodule

// File: rtl/psp_handshake.sv
module psp_handshake
    import par_sample_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_ev,
    input  logic             fall_ev,
    input  logic             ack,
    input  logic             src_empty,
    input  sample_t          head,
    output logic             pop,
    output logic             req,
    output logic [SMP_W-1:0] data,
    output logic [CH_W-1:0]  chan,
    output logic             iq
);
    typedef struct packed {
        logic             req;
        logic             acc;
        logic             iq;
        logic [CH_W-1:0]  chan;
        logic [SMP_W-1:0] data;
        logic [SMP_W-1:0] held;
    } st_t;

    st_t  st_q, st_d;
    logic want_next;

    always_comb begin
        st_d      = st_q;
        pop       = 1'b0;
        want_next = 1'b0;
        if (fall_ev && st_q.req && ack) st_d.acc = 1'b1;
        if (rise_ev) begin
            if (st_q.req && st_q.acc) begin
                if (st_q.iq) begin
                    st_d.data = st_q.held;
                    st_d.iq   = 1'b0;
                    st_d.acc  = 1'b0;
                end else begin
                    want_next = 1'b1;
                end
            end else if (!st_q.req) begin
                want_next = 1'b1;
            end
        end
        if (want_next) begin
            st_d.acc = 1'b0;
            if (!src_empty) begin
                pop       = 1'b1;
                st_d.req  = 1'b1;
                st_d.iq   = 1'b1;
                st_d.chan = head.chan;
                st_d.data = head.i;
                st_d.held = head.q;
            end else begin
                st_d.req = 1'b0;
            end
        end
        req  = st_q.req;
        data = st_q.data;
        chan = st_q.chan;
        iq   = st_q.iq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/par_sample_port.sv
module par_sample_port
    import par_sample_pkg::*;
#(
    parameter int NSRC  = 6,
    parameter int DEPTH = 4,
    parameter int DIVW  = 2,
    parameter int SYNC  = 2,
    localparam int SELW = $clog2(NSRC + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SELW-1:0]       src_sel,
    input  logic [NSRC-1:0]       src_valid,
    input  logic [NSRC*SMP_W-1:0] src_i,
    input  logic [NSRC*SMP_W-1:0] src_q,
    input  logic [NSRC*CH_W-1:0]  src_chan,
    input  logic                  clk_master,
    input  logic [DIVW-1:0]       clk_div,
    input  logic                  pclk_in,
    output logic                  pclk_out,
    output logic                  port_req,
    input  logic                  port_ack,
    output logic [SMP_W-1:0]      port_data,
    output logic [CH_W-1:0]       port_chan,
    output logic                  port_iq,
    output logic                  ovf_flag
);
    logic    mux_valid, rise_ev, fall_ev, buf_empty, pop;
    sample_t mux_smp, head;

    psp_srcmux #(.NSRC(NSRC), .SELW(SELW)) u_mux (
        .sel(src_sel), .valid(src_valid), .i_bus(src_i), .q_bus(src_q),
        .ch_bus(src_chan), .out_valid(mux_valid), .out_smp(mux_smp)
    );

    psp_fifo #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(mux_valid), .wr_data(mux_smp),
        .rd_en(pop), .rd_data(head), .empty(buf_empty), .ovf(ovf_flag)
    );

    psp_clkgen #(.DIVW(DIVW), .SYNC(SYNC)) u_clk (
        .clk(clk), .rst_n(rst_n), .master(clk_master), .div_exp(clk_div),
        .pclk_in(pclk_in), .pclk_out(pclk_out), .rise_ev(rise_ev), .fall_ev(fall_ev)
    );

    psp_handshake u_hs (
        .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .fall_ev(fall_ev),
        .ack(port_ack), .src_empty(buf_empty), .head(head), .pop(pop),
        .req(port_req), .data(port_data), .chan(port_chan), .iq(port_iq)
    );

endmodule

// File: rtl/par_sample_port_chk.sv
module par_sample_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clk_master,
    input logic        pclk_out,
    input logic        port_req,
    input logic [15:0] port_data,
    input logic [1:0]  port_chan,
    input logic        port_iq,
    input logic        ovf_flag
);
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R3
    i_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_req) |-> port_iq);

    // R3
    pair_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(port_iq) |-> (port_req && $stable(port_chan)));

    // R6
    req_after_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(port_req) |-> !$past(port_iq));

    // R5
    bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_master && $past(clk_master) && !$rose(pclk_out))
        |-> ($stable(port_req) && $stable(port_data) && $stable(port_iq) && $stable(port_chan)));

    // R8
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_master && !$past(clk_master)) |-> !pclk_out);

endmodule

bind par_sample_port par_sample_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .clk_master(clk_master), .pclk_out(pclk_out),
    .port_req(port_req), .port_data(port_data), .port_chan(port_chan),
    .port_iq(port_iq), .ovf_flag(ovf_flag)
);

// File: tb/par_sample_port_tb.sv
module par_sample_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_sel = 3'd0;
    logic [5:0]  src_valid = '0;
    logic [95:0] src_i = '0;
    logic [95:0] src_q = '0;
    logic [11:0] src_chan = '0;
    logic        clk_master = 1'b1;
    logic [1:0]  clk_div = 2'd0;
    logic        pclk_in = 1'b0;
    logic        pclk_out, port_req, port_iq, ovf_flag;
    logic        port_ack = 1'b1;
    logic [15:0] port_data;
    logic [1:0]  port_chan;

    int vec = 0, err = 0, cyc = 0, rises = 0, ph_cnt = 0, ack_mode = 0, last_rise = -1;
    bit slave_run = 0, done = 0, mon_ok = 0;
    logic [18:0] exp_q[$];
    logic        prev_pc = 0, prev_req = 0, prev_ack = 0, prev_master = 1;
    logic [1:0]  prev_div = 0;
    logic [18:0] prev_word = '0;

    always #5 clk = ~clk;

    par_sample_port u_dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .src_valid(src_valid),
        .src_i(src_i), .src_q(src_q), .src_chan(src_chan), .clk_master(clk_master),
        .clk_div(clk_div), .pclk_in(pclk_in), .pclk_out(pclk_out), .port_req(port_req),
        .port_ack(port_ack), .port_data(port_data), .port_chan(port_chan),
        .port_iq(port_iq), .ovf_flag(ovf_flag)
    );

    function automatic void chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        vec++;
        if (!ok) begin
            err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endfunction

    function automatic logic ack_pat(int n);
        case (ack_mode)
            0:       return 1'b1;
            1:       return (n % 3) != 0;
            default: return 1'b0;
        endcase
    endfunction

    // port clock (slave) and acknowledge driver
    always @(posedge clk) begin
        #1;
        cyc++;
        if (slave_run) begin
            if (ph_cnt == 5) begin
                ph_cnt = 0;
                pclk_in = ~pclk_in;
                if (pclk_in) begin
                    rises++;
                    port_ack = ack_pat(rises);
                end
            end else ph_cnt++;
        end else begin
            port_ack = ack_pat(cyc);
        end
    end

    // behavioural observer at the ports
    always @(negedge clk) begin
        logic pc;
        logic [18:0] w, cur;
        bit same_cfg;
        if (rst_n) begin
            pc = clk_master ? pclk_out : pclk_in;
            cur = {port_chan, port_iq, port_data};
            same_cfg = clk_master && prev_master && (clk_div == prev_div);
            if (mon_ok) begin
                if (prev_pc && !pc && prev_req && prev_ack) begin
                    if (exp_q.size() == 0) chk(1'b0, "R4 word taken with none pending", 32'(prev_word), 0);
                    else begin
                        w = exp_q.pop_front();
                        chk(prev_word == w, "R3 R10 R4 transferred word", 32'(prev_word), 32'(w));
                    end
                end
                if (same_cfg && !(!prev_pc && pc))
                    chk({port_req, cur} == {prev_req, prev_word}, "R5 bus changed off rising edge",
                        32'({port_req, cur}), 32'({prev_req, prev_word}));
                if (prev_req && !port_req)
                    chk(exp_q.size() == 0, "R6 request dropped with words pending", exp_q.size(), 0);
                if (!clk_master && !prev_master)
                    chk(pclk_out == 1'b0, "R8 pclk_out in slave mode", 32'(pclk_out), 0);
                if (same_cfg && !prev_pc && pc) begin
                    if (last_rise >= 0)
                        chk((cyc - last_rise) == (2 << clk_div), "R7 port clock period",
                            cyc - last_rise, 2 << clk_div);
                    last_rise = cyc;
                end else if (!same_cfg) last_rise = -1;
            end
            mon_ok = 1;
            prev_pc = pc; prev_req = port_req; prev_ack = port_ack;
            prev_word = cur; prev_master = clk_master; prev_div = clk_div;
        end
    end

    task automatic push_one(input int s, input logic [1:0] ch, input logic [15:0] iv,
                            input logic [15:0] qv, input bit expect_it);
        @(posedge clk); #2;
        src_valid = '0;
        src_valid[s] = 1'b1;
        src_i[s*16 +: 16] = iv;
        src_q[s*16 +: 16] = qv;
        src_chan[s*2 +: 2] = ch;
        if (expect_it) begin
            exp_q.push_back({ch, 1'b1, iv});
            exp_q.push_back({ch, 1'b0, qv});
        end
        @(posedge clk); #2;
        src_valid = '0;
    endtask

    // all six sources strobe together; only the selected one may count (R2)
    task automatic push_mix(input int k);
        @(posedge clk); #2;
        for (int s = 0; s < 6; s++) begin
            src_valid[s] = 1'b1;
            src_i[s*16 +: 16] = 16'(16'h1000 * s + k);
            src_q[s*16 +: 16] = 16'(16'h8000 + 16'h0100 * s + k);
            src_chan[s*2 +: 2] = 2'(s + k);
        end
        if (src_sel < 6) begin
            exp_q.push_back({src_chan[src_sel*2 +: 2], 1'b1, src_i[src_sel*16 +: 16]});
            exp_q.push_back({src_chan[src_sel*2 +: 2], 1'b0, src_q[src_sel*16 +: 16]});
        end
        @(posedge clk); #2;
        src_valid = '0;
    endtask

    task automatic drain(input string tag);
        int t;
        t = 0;
        while ((exp_q.size() != 0 || port_req) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        chk(exp_q.size() == 0 && !port_req, tag, {exp_q.size(), 3'b0, port_req}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", vec, -1);
            $display("== %0d vectors applied, %0d miscompares ==", vec, err);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk({port_req, port_iq, port_data, port_chan, pclk_out, ovf_flag} == '0,
            "R1 outputs in reset", 32'({port_req, port_iq, port_data, port_chan, pclk_out, ovf_flag}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({port_req, port_iq, ovf_flag} == '0, "R1 outputs after reset",
            32'({port_req, port_iq, ovf_flag}), 0);

        // R3 R10 master d=0, full acknowledge
        src_sel = 3'd2;
        for (int n = 0; n < 4; n++) push_one(2, 2'(n), 16'(16'hA000 + n), 16'(16'h5000 + n), 1);
        drain("R6 R3 drain d=0");

        // R2 R7 each divisor, mixed sources, sparse acknowledge
        ack_mode = 1;
        for (int d = 1; d < 4; d++) begin
            @(posedge clk); #2;
            clk_div = 2'(d);
            src_sel = 3'(d + 2);
            repeat (40) @(posedge clk);
            for (int k = 0; k < 4; k++) push_mix(k + 8 * d);
            drain("R2 R7 drain per divisor");
        end

        // R2 selector value with no source
        src_sel = 3'd6;
        for (int k = 0; k < 3; k++) push_mix(k);
        repeat (60) @(negedge clk);
        chk(port_req == 1'b0, "R2 select 6 admits nothing", 32'(port_req), 0);
        src_sel = 3'd7;
        push_mix(5);
        repeat (60) @(negedge clk);
        chk(port_req == 1'b0, "R2 select 7 admits nothing", 32'(port_req), 0);

        // R8 slave mode
        @(posedge clk); #2;
        clk_master = 1'b0;
        slave_run = 1;
        repeat (30) @(posedge clk);
        src_sel = 3'd5;
        for (int n = 0; n < 4; n++) push_one(5, 2'(3 - n), 16'(16'h0F00 + n), 16'(16'h7700 + n), 1);
        drain("R8 slave drain");
        @(posedge clk); #2;
        slave_run = 0;
        clk_master = 1'b1;
        clk_div = 2'd0;

        // R9 overflow: hold acknowledge low
        ack_mode = 2;
        src_sel = 3'd1;
        repeat (10) @(posedge clk);
        push_one(1, 2'd1, 16'hC000, 16'h3000, 1);
        while (!port_req) @(negedge clk);
        chk(ovf_flag == 1'b0, "R9 no overflow yet", 32'(ovf_flag), 0);
        for (int n = 1; n <= 6; n++)
            push_one(1, 2'(n), 16'(16'hC000 + n), 16'(16'h3000 + n), n <= 4);
        repeat (3) @(negedge clk);
        chk(ovf_flag == 1'b1, "R9 overflow flagged", 32'(ovf_flag), 1);
        chk(port_req && port_iq && port_data == 16'hC000, "R4 word held without acknowledge",
            32'({port_req, port_iq, port_data}), 32'({2'b11, 16'hC000}));
        ack_mode = 0;
        drain("R9 R10 drain after overflow");
        chk(ovf_flag == 1'b1, "R9 flag sticky", 32'(ovf_flag), 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, err);
        $finish;
    end
endmodule